// File: doc/BRIEF.md
# Tile Binner and Tile Sequencer

This block sits after the geometry stage of a renderer that sorts work by screen region. Each incoming triangle arrives as an already transformed screen-space bounding box together with a primitive index. The block works out which screen tiles the box covers and appends the index to the list kept for each of those tiles. All lists live in storage inside the block. While binning is in progress, nothing is sent downstream.

When the frame-end marker is accepted, the block switches to its release phase. It walks the tile grid in row-major order, with the column changing fastest. For each tile it streams the stored indices in the order they were submitted and marks the first and last cycle of the tile. A tile with no triangles still takes one cycle, so the tile buffer downstream can clear and write it back. One cycle after the last tile, a done pulse is raised, the lists are emptied, and binning of the next frame can begin.

Each tile list holds a fixed number of entries. Any entry beyond that number is discarded, and a sticky flag records that this happened.

Top module: `tile_binner`

## Requirements
- R1: The tile range of a box is computed as follows. Shift each corner coordinate right by TILE_SHIFT, then clamp it to the last column (TILES_X-1) or the last row (TILES_Y-1). With the defaults, tiles are 16x16 pixels on a grid of 4 columns by 3 rows, so a box lying wholly beyond the screen lands in the edge tiles.
- R2: An accepted triangle's index is appended to every tile in its clamped range. The block writes one tile per clock, and `tri_ready` stays low for exactly as many cycles as the number of tiles covered.
- R3: Within each tile, indices come out in the order in which their triangles were accepted.
- R4: Each tile list holds LIST_DEPTH entries. An entry for a full list is dropped and sets `list_overflow`, which then stays high until reset.
- R5: `frame_end` is acted on only in a cycle where `tri_ready` is high and `tri_valid` is low. If it is raised while a triangle is being binned, it has no effect and no release phase starts.
- R6: No output activity (`out_valid`, `tile_start`, `tile_end`, `frame_done`) occurs while binning. Release starts in the cycle after `frame_end` is accepted, with tile (0,0), and then follows row-major order.
- R7: A non-empty tile takes one cycle per stored entry. In each of these cycles `out_valid` is high and `out_id` carries the entry. `tile_start` is high on the first entry and `tile_end` on the last. `tile_col` and `tile_row` name the tile being released.
- R8: An empty tile takes exactly one cycle, with `tile_start` and `tile_end` both high and `out_valid` low.
- R9: `frame_done` is high for exactly one cycle, the cycle after the last tile ends. In the cycle after that, `tri_ready` is high again and every list is empty.
- R10: After reset, `tri_ready` is high and `out_valid`, `tile_start`, `tile_end`, `frame_done` and `list_overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tri_valid | input | 1 | Triangle present on the box and id inputs |
| tri_ready | output | 1 | Block can accept a triangle or the frame-end marker |
| box_x0 | input | COORD_W | Bounding box minimum x in pixels |
| box_y0 | input | COORD_W | Bounding box minimum y in pixels |
| box_x1 | input | COORD_W | Bounding box maximum x in pixels |
| box_y1 | input | COORD_W | Bounding box maximum y in pixels |
| tri_id | input | IDX_W | Primitive index to store |
| frame_end | input | 1 | All triangles of the frame have been sent |
| out_valid | output | 1 | `out_id` carries a stored index |
| out_id | output | IDX_W | Primitive index of the tile being released |
| tile_start | output | 1 | First cycle of a tile |
| tile_end | output | 1 | Last cycle of a tile |
| tile_col | output | TX_W | Column of the tile being released |
| tile_row | output | TY_W | Row of the tile being released |
| frame_done | output | 1 | One-cycle pulse after the last tile |
| list_overflow | output | 1 | Sticky flag: an entry was dropped from a full list |

## Verification
The assertions assume two things about the producer. First, every box it sends has its minimum corner no greater than its maximum corner in both axes. Second, it never raises `tri_valid` and `frame_end` in the same cycle. The bench keeps to both rules: each box is written with ordered corners, and stimulus is driven only on falling edges, one kind at a time. `frame_end` is raised during a walk only to confirm that it is ignored there.

// File: rtl/tbin_pkg.sv
package tbin_pkg;

    typedef enum logic [1:0] {
        ST_BIN  = 2'd0,
        ST_WALK = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } tbin_state_e;

    // Pixel coordinate to tile coordinate, clamped to the grid edge.
    function automatic int unsigned tile_of(int unsigned coord,
                                            int unsigned shift,
                                            int unsigned limit);
        int unsigned t;
        t = coord >> shift;
        return (t > limit - 1) ? limit - 1 : t;
    endfunction

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tbin_span.sv
module tbin_span
    import tbin_pkg::*;
#(
    parameter int COORD_W    = 10,
    parameter int TILE_SHIFT = 4,
    parameter int TILES_X    = 4,
    parameter int TILES_Y    = 3,
    localparam int TX_W      = width_of(TILES_X),
    localparam int TY_W      = width_of(TILES_Y)
) (
    input  logic [COORD_W-1:0] x_lo,
    input  logic [COORD_W-1:0] y_lo,
    input  logic [COORD_W-1:0] x_hi,
    input  logic [COORD_W-1:0] y_hi,
    output logic [TX_W-1:0]    col_lo,
    output logic [TX_W-1:0]    col_hi,
    output logic [TY_W-1:0]    row_lo,
    output logic [TY_W-1:0]    row_hi
);

    always_comb begin
        col_lo = TX_W'(tile_of(32'(x_lo), TILE_SHIFT, TILES_X));
        col_hi = TX_W'(tile_of(32'(x_hi), TILE_SHIFT, TILES_X));
        row_lo = TY_W'(tile_of(32'(y_lo), TILE_SHIFT, TILES_Y));
        row_hi = TY_W'(tile_of(32'(y_hi), TILE_SHIFT, TILES_Y));
    end

endmodule

// File: rtl/tbin_lists.sv
module tbin_lists
    import tbin_pkg::*;
#(
    parameter int NT         = 12,
    parameter int LIST_DEPTH = 4,
    parameter int IDX_W      = 8,
    localparam int T_W       = width_of(NT),
    localparam int K_W       = width_of(LIST_DEPTH),
    localparam int CNT_W     = $clog2(LIST_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [T_W-1:0]   wr_tile,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [T_W-1:0]   rd_tile,
    input  logic [K_W-1:0]   rd_k,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    output logic             ovf
);

    logic [IDX_W-1:0] mem [NT][LIST_DEPTH];
    logic [CNT_W-1:0] cnt [NT];
    logic             full;

    assign full   = (cnt[wr_tile] == CNT_W'(LIST_DEPTH));
    assign rd_idx = mem[rd_tile][rd_k];
    assign rd_cnt = cnt[rd_tile];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) cnt[t] <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            for (int t = 0; t < NT; t++) cnt[t] <= '0;
        end else if (wr_en) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                mem[wr_tile][K_W'(cnt[wr_tile])] <= wr_idx;
                cnt[wr_tile] <= cnt[wr_tile] + CNT_W'(1);
            end
        end
    end

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wr_en && full |=> ovf); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R4

    for (genvar g = 0; g < NT; g++) begin : g_tile_chk
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt[g] <= CNT_W'(LIST_DEPTH)); // R4
        AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
            clr |=> cnt[g] == '0); // R9
    end

endmodule

// File: rtl/tbin_emit.sv
module tbin_emit
    import tbin_pkg::*;
#(
    parameter int TILES_X    = 4,
    parameter int TILES_Y    = 3,
    parameter int LIST_DEPTH = 4,
    localparam int NT        = TILES_X * TILES_Y,
    localparam int TX_W      = width_of(TILES_X),
    localparam int TY_W      = width_of(TILES_Y),
    localparam int T_W       = width_of(NT),
    localparam int K_W       = width_of(LIST_DEPTH),
    localparam int CNT_W     = $clog2(LIST_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic             busy,
    output logic [TX_W-1:0]  col,
    output logic [TY_W-1:0]  row,
    output logic [T_W-1:0]   rd_tile,
    output logic [K_W-1:0]   rd_k,
    output logic             has_entry,
    output logic             tile_start,
    output logic             tile_end,
    output logic             all_fin
);

    logic tile_fin, last_tile;

    assign tile_fin   = (rd_cnt == '0) || (CNT_W'(rd_k) == rd_cnt - CNT_W'(1));
    assign last_tile  = (col == TX_W'(TILES_X - 1)) && (row == TY_W'(TILES_Y - 1));
    assign rd_tile    = T_W'(row) * T_W'(TILES_X) + T_W'(col);
    assign has_entry  = busy && (rd_cnt != '0);
    assign tile_start = busy && (rd_k == '0);
    assign tile_end   = busy && tile_fin;
    assign all_fin    = busy && tile_fin && last_tile;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            col  <= '0;
            row  <= '0;
            rd_k <= '0;
        end else if (go) begin
            busy <= 1'b1;
            col  <= '0;
            row  <= '0;
            rd_k <= '0;
        end else if (busy) begin
            if (tile_fin) begin
                rd_k <= '0;
                if (col == TX_W'(TILES_X - 1)) begin
                    col <= '0;
                    if (row == TY_W'(TILES_Y - 1)) begin
                        row  <= '0;
                        busy <= 1'b0;
                    end else begin
                        row <= row + TY_W'(1);
                    end
                end else begin
                    col <= col + TX_W'(1);
                end
            end else begin
                rd_k <= rd_k + K_W'(1);
            end
        end
    end

    AST_END_THEN_START: assert property (@(posedge clk) disable iff (rst)
        tile_end && !all_fin |=> tile_start); // R7
    AST_START_ROW_MAJOR: assert property (@(posedge clk) disable iff (rst)
        go |=> busy && col == '0 && row == '0); // R6

endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tbin_pkg::*;
#(
    parameter int COORD_W    = 10,
    parameter int IDX_W      = 8,
    parameter int TILE_SHIFT = 4,
    parameter int TILES_X    = 4,
    parameter int TILES_Y    = 3,
    parameter int LIST_DEPTH = 4,
    localparam int NT        = TILES_X * TILES_Y,
    localparam int TX_W      = width_of(TILES_X),
    localparam int TY_W      = width_of(TILES_Y),
    localparam int T_W       = width_of(NT),
    localparam int K_W       = width_of(LIST_DEPTH),
    localparam int CNT_W     = $clog2(LIST_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tri_valid,
    output logic               tri_ready,
    input  logic [COORD_W-1:0] box_x0,
    input  logic [COORD_W-1:0] box_y0,
    input  logic [COORD_W-1:0] box_x1,
    input  logic [COORD_W-1:0] box_y1,
    input  logic [IDX_W-1:0]   tri_id,
    input  logic               frame_end,
    output logic               out_valid,
    output logic [IDX_W-1:0]   out_id,
    output logic               tile_start,
    output logic               tile_end,
    output logic [TX_W-1:0]    tile_col,
    output logic [TY_W-1:0]    tile_row,
    output logic               frame_done,
    output logic               list_overflow
);

    tbin_state_e st;

    logic [TX_W-1:0]  sx0, sx1, rx0, rx1, cx;
    logic [TY_W-1:0]  sy0, sy1, ry1, cy;
    logic [IDX_W-1:0] rid;
    logic             go, walk_last, wr_en, clr;
    logic [T_W-1:0]   wr_tile, rd_tile;
    logic [K_W-1:0]   rd_k;
    logic [CNT_W-1:0] rd_cnt;
    logic             busy, all_fin;

    tbin_span #(
        .COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT),
        .TILES_X(TILES_X), .TILES_Y(TILES_Y)
    ) u_span (
        .x_lo(box_x0), .y_lo(box_y0), .x_hi(box_x1), .y_hi(box_y1),
        .col_lo(sx0), .col_hi(sx1), .row_lo(sy0), .row_hi(sy1)
    );

    assign tri_ready  = (st == ST_BIN);
    assign go         = (st == ST_BIN) && !tri_valid && frame_end;
    assign walk_last  = (cx == rx1) && (cy == ry1);
    assign wr_en      = (st == ST_WALK);
    assign wr_tile    = T_W'(cy) * T_W'(TILES_X) + T_W'(cx);
    assign clr        = (st == ST_DONE);
    assign frame_done = (st == ST_DONE);

    tbin_lists #(
        .NT(NT), .LIST_DEPTH(LIST_DEPTH), .IDX_W(IDX_W)
    ) u_lists (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_tile(wr_tile), .wr_idx(rid),
        .rd_tile(rd_tile), .rd_k(rd_k),
        .rd_idx(out_id), .rd_cnt(rd_cnt), .ovf(list_overflow)
    );

    tbin_emit #(
        .TILES_X(TILES_X), .TILES_Y(TILES_Y), .LIST_DEPTH(LIST_DEPTH)
    ) u_emit (
        .clk(clk), .rst(rst), .go(go), .rd_cnt(rd_cnt),
        .busy(busy), .col(tile_col), .row(tile_row),
        .rd_tile(rd_tile), .rd_k(rd_k), .has_entry(out_valid),
        .tile_start(tile_start), .tile_end(tile_end), .all_fin(all_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_BIN;
            rx0 <= '0;
            rx1 <= '0;
            ry1 <= '0;
            cx  <= '0;
            cy  <= '0;
            rid <= '0;
        end else begin
            unique case (st)
                ST_BIN: begin
                    if (tri_valid) begin
                        rx0 <= sx0;
                        rx1 <= sx1;
                        ry1 <= sy1;
                        cx  <= sx0;
                        cy  <= sy0;
                        rid <= tri_id;
                        st  <= ST_WALK;
                    end else if (frame_end) begin
                        st <= ST_EMIT;
                    end
                end
                ST_WALK: begin
                    if (walk_last) begin
                        st <= ST_BIN;
                    end else if (cx == rx1) begin
                        cx <= rx0;
                        cy <= cy + TY_W'(1);
                    end else begin
                        cx <= cx + TX_W'(1);
                    end
                end
                ST_EMIT: if (all_fin) st <= ST_DONE;
                ST_DONE: st <= ST_BIN;
                default: st <= ST_BIN;
            endcase
        end
    end

    AST_BOX_ORDERED: assert property (@(posedge clk) disable iff (rst)
        tri_valid && tri_ready |-> sx0 <= sx1 && sy0 <= sy1); // R1
    AST_WALK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st == ST_WALK |-> cx >= rx0 && cx <= rx1 && cy <= ry1); // R2
    AST_QUIET_BINNING: assert property (@(posedge clk) disable iff (rst)
        tri_ready |-> !out_valid && !tile_start && !tile_end && !busy); // R6
    AST_WALK_IGNORES_END: assert property (@(posedge clk) disable iff (rst)
        st == ST_WALK |=> !busy); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        all_fin |=> frame_done); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done && tri_ready); // R9

endmodule

// File: tb/sim_tile_binner.sv
module sim_tile_binner;

    localparam int TX = 4;
    localparam int TY = 3;
    localparam int DEP = 4;
    localparam int SH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tri_valid = 1'b0;
    logic       tri_ready;
    logic [9:0] box_x0 = '0, box_y0 = '0, box_x1 = '0, box_y1 = '0;
    logic [7:0] tri_id = '0;
    logic       frame_end = 1'b0;
    logic       out_valid;
    logic [7:0] out_id;
    logic       tile_start, tile_end;
    logic [1:0] tile_col;
    logic [1:0] tile_row;
    logic       frame_done, list_overflow;

    int nchk = 0;
    int nerr = 0;
    int mlst [TX*TY][DEP];
    int mcnt [TX*TY];
    bit movf = 1'b0;

    always #5 clk = ~clk;

    tile_binner u0 (
        .clk(clk), .rst(rst), .tri_valid(tri_valid), .tri_ready(tri_ready),
        .box_x0(box_x0), .box_y0(box_y0), .box_x1(box_x1), .box_y1(box_y1),
        .tri_id(tri_id), .frame_end(frame_end),
        .out_valid(out_valid), .out_id(out_id),
        .tile_start(tile_start), .tile_end(tile_end),
        .tile_col(tile_col), .tile_row(tile_row),
        .frame_done(frame_done), .list_overflow(list_overflow)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tclamp(int c, int lim);
        int v;
        v = c >> SH;
        return (v > lim - 1) ? lim - 1 : v;
    endfunction

    // Submit one triangle; optionally raise frame_end in the middle of its walk.
    task automatic submit(int x0, int y0, int x1, int y1, int id, bit poke_end);
        int c0, c1, r0, r1, n, want;
        c0 = tclamp(x0, TX); c1 = tclamp(x1, TX);
        r0 = tclamp(y0, TY); r1 = tclamp(y1, TY);
        want = (c1 - c0 + 1) * (r1 - r0 + 1);
        chk("R2 ready before submit", int'(tri_ready), 1);
        box_x0 = 10'(x0); box_y0 = 10'(y0); box_x1 = 10'(x1); box_y1 = 10'(y1);
        tri_id = 8'(id);
        tri_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tri_valid = 1'b0;
        n = 0;
        while (!tri_ready && n < 64) begin
            chk("R6 quiet while binning", int'(out_valid | tile_start | tile_end | frame_done), 0);
            n++;
            frame_end = poke_end && (n == 1);
            @(negedge clk);
        end
        frame_end = 1'b0;
        chk("R2 walk cycles equal tiles covered", n, want);
        for (int r = r0; r <= r1; r++) begin
            for (int c = c0; c <= c1; c++) begin
                int t;
                t = r * TX + c;
                if (mcnt[t] < DEP) begin
                    mlst[t][mcnt[t]] = id;
                    mcnt[t]++;
                end else begin
                    movf = 1'b1;
                end
            end
        end
        chk("R4 overflow flag after walk", int'(list_overflow), int'(movf));
        if (poke_end) begin
            for (int i = 0; i < 3; i++) begin
                chk("R5 frame_end during walk ignored", int'(out_valid | tile_start | frame_done), 0);
                chk("R5 still binning", int'(tri_ready), 1);
                @(negedge clk);
            end
        end
    endtask

    task automatic release_frame();
        frame_end = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_end = 1'b0;
        for (int r = 0; r < TY; r++) begin
            for (int c = 0; c < TX; c++) begin
                int t;
                t = r * TX + c;
                if (mcnt[t] == 0) begin
                    chk("R8 empty tile valid low", int'(out_valid), 0);
                    chk("R8 empty tile start", int'(tile_start), 1);
                    chk("R8 empty tile end", int'(tile_end), 1);
                    chk("R6 row-major col", int'(tile_col), c);
                    chk("R6 row-major row", int'(tile_row), r);
                    chk("R9 no early done", int'(frame_done), 0);
                    @(negedge clk);
                end else begin
                    for (int k = 0; k < mcnt[t]; k++) begin
                        chk("R7 valid", int'(out_valid), 1);
                        chk("R3 submission order id", int'(out_id), mlst[t][k]);
                        chk("R7 tile_start", int'(tile_start), int'(k == 0));
                        chk("R7 tile_end", int'(tile_end), int'(k == mcnt[t] - 1));
                        chk("R7 tile col", int'(tile_col), c);
                        chk("R7 tile row", int'(tile_row), r);
                        chk("R9 no early done", int'(frame_done), 0);
                        @(negedge clk);
                    end
                end
            end
        end
        chk("R9 done pulse", int'(frame_done), 1);
        chk("R9 no output with done", int'(out_valid | tile_start), 0);
        @(negedge clk);
        chk("R9 done single cycle", int'(frame_done), 0);
        chk("R9 ready after done", int'(tri_ready), 1);
        chk("R4 overflow sticky", int'(list_overflow), int'(movf));
        for (int t = 0; t < TX * TY; t++) mcnt[t] = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int t = 0; t < TX * TY; t++) mcnt[t] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset ready", int'(tri_ready), 1);
        chk("R10 reset valid", int'(out_valid), 0);
        chk("R10 reset start/end", int'(tile_start | tile_end), 0);
        chk("R10 reset done", int'(frame_done), 0);
        chk("R10 reset overflow", int'(list_overflow), 0);

        // Frame 1: overlapping boxes, clamping, full-screen box, end-marker poke.
        submit(3, 2, 20, 18, 5, 1'b1);        // R1 2x2 tiles
        submit(40, 40, 100, 200, 9, 1'b0);    // R1 clamps right and bottom
        submit(0, 0, 0, 0, 1, 1'b0);          // single tile
        submit(0, 0, 1023, 1023, 200, 1'b0);  // every tile
        submit(900, 900, 950, 960, 77, 1'b0); // wholly off-screen -> corner
        release_frame();

        // Frame 2: overflow one tile, plus one other entry.
        for (int i = 0; i < 5; i++) submit(16, 16, 31, 31, 10 + i, 1'b0);
        submit(50, 0, 63, 10, 42, 1'b0);
        release_frame();

        // Frame 3: empty frame.
        @(negedge clk);
        release_frame();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule